// File: doc/BRIEF.md
# Interval Watchdog Timer with Early Warning

This block is a watchdog timer driven by one 32-bit control and status word. Software picks a clock divider code and an interval code, turns on counting, and restarts ("kicks") the count from time to time by writing the word back with the restart bit set. A prescaler divides the input clock by the ratio the divider code selects. Each prescaled tick advances an up-counter, and the counter expires after the number of ticks the interval code selects.

When the interval expires, a sticky warning flag sets. If the interrupt enable is on, the interrupt output goes high. Counting then goes on into a fixed grace window. If software has not restarted the count by the end of that window and reset is enabled, the block drives a system reset pulse of fixed length and sets a sticky reset flag. Software clears each flag by writing 1 to it. Writing zero to the whole word stops the timer.

Top module: `intvl_watchdog`

## Requirements
- R1: After reset, `rdData` reads 0 and both `irqOut` and `sysRstOut` are low.
- R2: Field positions in the word: [11:10] divider code, [7] count enable, [6] interrupt enable, [5:4] interval code, [3] warning flag, [2] reset flag, [1] reset enable, [0] restart. Bits 31:12, 9:8 and 0 always read 0. A write with count enable 0 stores the writable fields and they read back unchanged.
- R3: Divider code 0 gives one prescaled tick per clock. Codes 1, 2 and 3 give one tick per `BASE_DIV`, 8×`BASE_DIV` and 256×`BASE_DIV` clocks.
- R4: Interval code k gives an interval of `BASE_TICKS`×4^k ticks. After a write that sets the restart bit with count enable 1, the warning flag (bit 3) reads 1 exactly ratio×interval clock edges after the write edge, and reads 0 one edge earlier.
- R5: The warning flag sets on expiry whatever the interrupt enable is. `irqOut` is high exactly when the warning flag and the interrupt enable are both 1.
- R6: Writing 1 to bit 0 restarts the prescaler and the interval count without changing the other fields, so the next expiry falls a full interval after that write.
- R7: A write that changes the divider code or the interval code clears the count at that write. A write with both codes unchanged and bit 0 at 0 leaves the count running.
- R8: `GRACE_TICKS` ticks after expiry, if the count has not been restarted and reset enable is 1, `sysRstOut` goes high on the edge where the reset flag (bit 2) sets and stays high for `PULSE_LEN` clocks. With reset enable 0, neither happens.
- R9: The flags are sticky. Writing 1 to bit 3 or bit 2 clears that flag, and writing 0 there leaves it as it is.
- R10: Writing all zeros clears count enable, interrupt enable and reset enable. No expiry occurs while count enable is 0.
- R11: Writing restart, reset enable and count enable with both codes at 0 produces the shortest path to reset: the pulse starts `BASE_TICKS`+`GRACE_TICKS` clocks after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 32 | Value written to the control word |
| rdData | output | 32 | Current value of the control word |
| irqOut | output | 1 | Early warning interrupt |
| sysRstOut | output | 1 | System reset pulse |

## Verification
The checker watches several properties on every cycle. It checks that the interrupt never rises without both its enable and its flag, and that the warning flag stays set until a write clears it. It also checks that a write of zero drops all three enables, that no expiry occurs while counting is off, and that every reset pulse starts together with a set reset flag. Only the directed scenarios can show exact timing: the edge where each divider/interval pair expires, that a restart or a field change moves that edge, the length of the grace window and the pulse, and the readback layout.

// File: rtl/intvl_watchdog_pkg.sv
package intvl_watchdog_pkg;

  // Bit positions of the control and status word
  localparam int POS_RESTART = 0;
  localparam int POS_RSTEN   = 1;
  localparam int POS_RSTFLAG = 2;
  localparam int POS_IRQFLAG = 3;
  localparam int POS_IVL     = 4;   // two bits
  localparam int POS_IRQEN   = 6;
  localparam int POS_EN      = 7;
  localparam int POS_DIV     = 10;  // two bits

  // Control -> datapath strobes
  typedef struct packed {
    logic       run;
    logic       clear;
    logic [1:0] divSel;
    logic [1:0] ivlSel;
    logic       rstArm;
  } ctlStrobes_t;

  // Datapath -> control events
  typedef struct packed {
    logic expire;
    logic fire;
  } dpEvents_t;

endpackage

// File: rtl/intvl_watchdog_ctrl.sv
module intvl_watchdog_ctrl
  import intvl_watchdog_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  dpEvents_t        evt,
  output ctlStrobes_t      strb,
  output logic [REG_W-1:0] rdData,
  output logic             irqOut
);

  logic [1:0] divSel;
  logic [1:0] ivlSel;
  logic       enBit;
  logic       irqEn;
  logic       rstEn;
  logic       irqFlag;
  logic       rstFlag;

  logic [1:0] wrDiv;
  logic [1:0] wrIvl;
  logic       cfgChange;
  logic       clrIrq;
  logic       clrRst;

  assign wrDiv     = wrData[POS_DIV +: 2];
  assign wrIvl     = wrData[POS_IVL +: 2];
  assign cfgChange = (wrDiv != divSel) || (wrIvl != ivlSel);
  assign clrIrq    = wrEn && wrData[POS_IRQFLAG];
  assign clrRst    = wrEn && wrData[POS_RSTFLAG];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divSel  <= '0;
      ivlSel  <= '0;
      enBit   <= 1'b0;
      irqEn   <= 1'b0;
      rstEn   <= 1'b0;
      irqFlag <= 1'b0;
      rstFlag <= 1'b0;
    end else begin
      if (wrEn) begin
        divSel <= wrDiv;
        ivlSel <= wrIvl;
        enBit  <= wrData[POS_EN];
        irqEn  <= wrData[POS_IRQEN];
        rstEn  <= wrData[POS_RSTEN];
      end
      // a new event wins over a clear in the same cycle
      irqFlag <= evt.expire | (irqFlag & ~clrIrq);
      rstFlag <= evt.fire   | (rstFlag & ~clrRst);
    end
  end

  always_comb begin
    strb.run    = enBit;
    strb.clear  = wrEn && (wrData[POS_RESTART] || cfgChange);
    strb.divSel = divSel;
    strb.ivlSel = ivlSel;
    strb.rstArm = rstEn;
  end

  always_comb begin
    rdData                 = '0;
    rdData[POS_DIV +: 2]   = divSel;
    rdData[POS_EN]         = enBit;
    rdData[POS_IRQEN]      = irqEn;
    rdData[POS_IVL +: 2]   = ivlSel;
    rdData[POS_IRQFLAG]    = irqFlag;
    rdData[POS_RSTFLAG]    = rstFlag;
    rdData[POS_RSTEN]      = rstEn;
  end

  assign irqOut = irqFlag & irqEn;

  logic unusedWrBits;
  assign unusedWrBits = ^{wrData[REG_W-1:12], wrData[9:8]};

endmodule

// File: rtl/intvl_watchdog_dp.sv
module intvl_watchdog_dp
  import intvl_watchdog_pkg::*;
#(
  parameter int BASE_DIV    = 4096,
  parameter int BASE_TICKS  = 32,
  parameter int GRACE_TICKS = 1024,
  parameter int PULSE_LEN   = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strb,
  output dpEvents_t   evt,
  output logic        sysRstOut
);

  localparam int RATIO1  = BASE_DIV;
  localparam int RATIO2  = 8 * BASE_DIV;
  localparam int RATIO3  = 256 * BASE_DIV;
  localparam int PRE_W   = (RATIO3 > 2) ? $clog2(RATIO3) : 1;
  localparam int IVL0    = BASE_TICKS;
  localparam int IVL1    = 4 * BASE_TICKS;
  localparam int IVL2    = 16 * BASE_TICKS;
  localparam int IVL3    = 64 * BASE_TICKS;
  localparam int CNT_MAX = (IVL3 > GRACE_TICKS) ? IVL3 : GRACE_TICKS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int PUL_W   = $clog2(PULSE_LEN + 1);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] ratioM1;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limM1;
  logic             inGrace;
  logic [PUL_W-1:0] pulseCnt;

  logic tick;
  logic ivlEnd;
  logic graceEnd;
  logic active;

  always_comb begin
    case (strb.divSel)
      2'd0:    ratioM1 = '0;
      2'd1:    ratioM1 = PRE_W'(RATIO1 - 1);
      2'd2:    ratioM1 = PRE_W'(RATIO2 - 1);
      default: ratioM1 = PRE_W'(RATIO3 - 1);
    endcase
  end

  always_comb begin
    case (strb.ivlSel)
      2'd0:    limM1 = CNT_W'(IVL0 - 1);
      2'd1:    limM1 = CNT_W'(IVL1 - 1);
      2'd2:    limM1 = CNT_W'(IVL2 - 1);
      default: limM1 = CNT_W'(IVL3 - 1);
    endcase
  end

  assign active   = strb.run && !strb.clear;
  assign tick     = active && (preCnt == ratioM1);
  assign ivlEnd   = tick && !inGrace && (cnt == limM1);
  assign graceEnd = tick && inGrace && (cnt == CNT_W'(GRACE_TICKS - 1));

  // prescaler and interval/grace counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt  <= '0;
      cnt     <= '0;
      inGrace <= 1'b0;
    end else if (!active) begin
      preCnt  <= '0;
      cnt     <= '0;
      inGrace <= 1'b0;
    end else if (tick) begin
      preCnt <= '0;
      if (ivlEnd) begin
        cnt     <= '0;
        inGrace <= 1'b1;
      end else if (graceEnd) begin
        cnt     <= '0;
        inGrace <= 1'b0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  always_comb begin
    evt.expire = ivlEnd;
    evt.fire   = graceEnd && strb.rstArm;
  end

  // reset pulse stretcher
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (evt.fire) begin
      pulseCnt <= PUL_W'(PULSE_LEN);
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - PUL_W'(1);
    end
  end

  assign sysRstOut = (pulseCnt != '0);

endmodule

// File: rtl/intvl_watchdog.sv
module intvl_watchdog
  import intvl_watchdog_pkg::*;
#(
  parameter int BASE_DIV    = 4096,
  parameter int BASE_TICKS  = 32,
  parameter int GRACE_TICKS = 1024,
  parameter int PULSE_LEN   = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        irqOut,
  output logic        sysRstOut
);

  ctlStrobes_t strb;
  dpEvents_t   evt;

  intvl_watchdog_ctrl #(
    .REG_W(32)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrData (wrData),
    .evt    (evt),
    .strb   (strb),
    .rdData (rdData),
    .irqOut (irqOut)
  );

  intvl_watchdog_dp #(
    .BASE_DIV    (BASE_DIV),
    .BASE_TICKS  (BASE_TICKS),
    .GRACE_TICKS (GRACE_TICKS),
    .PULSE_LEN   (PULSE_LEN)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .evt       (evt),
    .sysRstOut (sysRstOut)
  );

endmodule

// File: rtl/intvl_watchdog_chk.sv
module intvl_watchdog_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [31:0] wrData,
  input logic [31:0] rdData,
  input logic        irqOut,
  input logic        sysRstOut
);

  assert_irq_gated_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (rdData[6] && rdData[3]));

  assert_rst_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRstOut) |-> rdData[2]);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[3] && !(wrEn && wrData[3])) |=> rdData[3]);

  assert_stop_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrData == 32'd0)) |=> (rdData[7:6] == 2'b00 && !rdData[1]));

  assert_idle_no_expiry_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[7] |=> !$rose(rdData[3]));

endmodule

bind intvl_watchdog intvl_watchdog_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrData    (wrData),
  .rdData    (rdData),
  .irqOut    (irqOut),
  .sysRstOut (sysRstOut)
);

// File: tb/sim_intvl_watchdog.sv
module sim_intvl_watchdog;

  localparam int CLK_PERIOD = 10;
  // bench parameters: ratios 1,2,16,512; intervals 2,8,32,128 ticks
  localparam int P_BASE_DIV = 2;
  localparam int P_BASE_TKS = 2;
  localparam int P_GRACE    = 4;
  localparam int P_PULSE    = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut;
  logic        sysRstOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intvl_watchdog #(
    .BASE_DIV    (P_BASE_DIV),
    .BASE_TICKS  (P_BASE_TKS),
    .GRACE_TICKS (P_GRACE),
    .PULSE_LEN   (P_PULSE)
  ) u0 (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .rdData    (rdData),
    .irqOut    (irqOut),
    .sysRstOut (sysRstOut)
  );

  task automatic chkEq(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge; returns at the following negedge
  task automatic wr(input logic [31:0] v);
    wrData = v;
    wrEn   = 1'b1;
    @(negedge clk);
    wrEn   = 1'b0;
    wrData = '0;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stopClr();
    wr(32'h0000_000C);
    chkEq("R10", "stop and clear flags", rdData, 32'h0);
  endtask

  task automatic tResetState();
    chkEq("R1", "rdData after reset", rdData, 32'h0);
    chkEq("R1", "irqOut after reset", {31'b0, irqOut}, 32'h0);
    chkEq("R1", "sysRstOut after reset", {31'b0, sysRstOut}, 32'h0);
  endtask

  task automatic tReadback();
    wr(32'h0000_0F73);
    chkEq("R2", "readback of fields", rdData, 32'h0000_0C72);
    wr(32'h0000_0000);
    chkEq("R2", "readback after zero", rdData, 32'h0);
  endtask

  // fields carry divider and interval code; n = ratio * interval
  task automatic tTimeout(input string req, input logic [31:0] fields, input int n);
    wr(fields | 32'h0000_00C1);
    waitN(n - 1);
    chkEq(req, "flag one edge before expiry", {31'b0, rdData[3]}, 32'h0);
    waitN(1);
    chkEq(req, "flag at expiry", {31'b0, rdData[3]}, 32'h1);
    chkEq(req, "irqOut at expiry", {31'b0, irqOut}, 32'h1);
    stopClr();
  endtask

  task automatic tIrqGate();
    wr(32'h0000_0481);  // div 1, count enable, no interrupt enable
    waitN(4);
    chkEq("R5", "flag sets without irq enable", {31'b0, rdData[3]}, 32'h1);
    chkEq("R5", "irqOut stays low", {31'b0, irqOut}, 32'h0);
    wr(32'h0000_04C0);  // turn interrupt enable on, fields unchanged
    chkEq("R5", "irqOut after enable", {31'b0, irqOut}, 32'h1);
    stopClr();
  endtask

  task automatic tKick();
    wr(32'h0000_04D1);  // div 1, ivl 1: 16 clocks
    waitN(10);
    wr(32'h0000_04D1);
    chkEq("R6", "fields unchanged, bit0 reads 0", rdData, 32'h0000_04D0);
    waitN(15);
    chkEq("R6", "no expiry before full interval after kick", {31'b0, rdData[3]}, 32'h0);
    waitN(1);
    chkEq("R6", "expiry a full interval after kick", {31'b0, rdData[3]}, 32'h1);
    stopClr();
  endtask

  task automatic tFieldChange();
    wr(32'h0000_04D1);
    waitN(10);
    wr(32'h0000_04C0);  // interval code 1 -> 0, no restart bit
    waitN(3);
    chkEq("R7", "no expiry right after field change", {31'b0, rdData[3]}, 32'h0);
    waitN(1);
    chkEq("R7", "expiry one new interval after change", {31'b0, rdData[3]}, 32'h1);
    stopClr();
    wr(32'h0000_04D1);
    waitN(6);
    wr(32'h0000_04D0);  // same fields, restart bit 0: count continues
    waitN(8);
    chkEq("R7", "unchanged write keeps count (before)", {31'b0, rdData[3]}, 32'h0);
    waitN(1);
    chkEq("R7", "unchanged write keeps count (at)", {31'b0, rdData[3]}, 32'h1);
    stopClr();
  endtask

  task automatic tForcedReset();
    wr(32'h0000_0083);  // restart + reset enable + count enable, codes 0
    waitN(1);
    chkEq("R11", "no expiry yet", {31'b0, rdData[3]}, 32'h0);
    waitN(1);
    chkEq("R11", "expiry after BASE_TICKS clocks", {31'b0, rdData[3]}, 32'h1);
    waitN(3);
    chkEq("R8", "no pulse before grace end", {31'b0, sysRstOut}, 32'h0);
    chkEq("R8", "no reset flag before grace end", {31'b0, rdData[2]}, 32'h0);
    waitN(1);
    chkEq("R11", "pulse at BASE_TICKS+GRACE", {31'b0, sysRstOut}, 32'h1);
    chkEq("R8", "reset flag with pulse", {31'b0, rdData[2]}, 32'h1);
    wr(32'h0000_0000);  // stop; flags stay
    chkEq("R9", "write 0 leaves flags", rdData, 32'h0000_000C);
    waitN(14);
    chkEq("R8", "pulse still high at last clock", {31'b0, sysRstOut}, 32'h1);
    waitN(1);
    chkEq("R8", "pulse ends after PULSE_LEN", {31'b0, sysRstOut}, 32'h0);
    wr(32'h0000_0008);
    chkEq("R9", "clear warning flag only", rdData, 32'h0000_0004);
    wr(32'h0000_0004);
    chkEq("R9", "clear reset flag", rdData, 32'h0);
  endtask

  task automatic tNoRstEn();
    wr(32'h0000_0081);
    waitN(6);
    chkEq("R8", "no pulse without reset enable", {31'b0, sysRstOut}, 32'h0);
    chkEq("R8", "no reset flag without reset enable", {31'b0, rdData[2]}, 32'h0);
    waitN(6);
    chkEq("R8", "still no pulse later", {31'b0, sysRstOut}, 32'h0);
    stopClr();
  endtask

  task automatic tStop();
    wr(32'h0000_04C3);
    waitN(2);
    wr(32'h0000_0000);
    waitN(10);
    chkEq("R10", "no expiry after stop", rdData, 32'h0);
    chkEq("R10", "irqOut low after stop", {31'b0, irqOut}, 32'h0);
  endtask

  initial begin
    waitN(3);
    rstN = 1'b1;
    waitN(1);
    tResetState();
    tReadback();
    tTimeout("R3", 32'h0000_0000, 2);    // div 0 ivl 0
    tTimeout("R3", 32'h0000_0400, 4);    // div 1 ivl 0
    tTimeout("R3", 32'h0000_0800, 32);   // div 2 ivl 0
    tTimeout("R3", 32'h0000_0C00, 1024); // div 3 ivl 0
    tTimeout("R4", 32'h0000_0410, 16);   // div 1 ivl 1
    tTimeout("R4", 32'h0000_0420, 64);   // div 1 ivl 2
    tTimeout("R4", 32'h0000_0430, 256);  // div 1 ivl 3
    tIrqGate();
    tKick();
    tFieldChange();
    tForcedReset();
    tNoRstEn();
    tStop();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL all-requirements watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule